// File: doc/BRIEF.md
# Real-time control line decoder

This block sits on the encoder side of a video pair and listens to a one-wire control stream. The decoder sends that stream once per video line. A frame opens with the line going from high to low. From that edge the block counts fixed-length time slots on the pixel clock. It reads one bit per slot, in the first clock of the slot, and ignores the remaining clocks.

Out of the frame it collects three kinds of data:
- a horizontal PLL increment, which is kept but feeds nothing;
- a subcarrier PLL increment;
- five flag bits: line sequence, phase reset, field rate, odd/even and colour detect.

Every received value first goes into shadow registers. The block moves all of them to its held registers in a single clock once the last slot of the frame ends.

A master enable and one enable per field decide, for each output, whether the held received value or the internal value drives it. The outputs are:
- the subcarrier increment that a synthesiser downstream should use;
- the field-rate flag;
- the odd/even flag;
- a one-clock subcarrier phase-reset strobe;
- a PAL line-inversion flag.

Top module: `rtc_line_decoder`

## Requirements
- R1: A synchronous active-low reset clears the counters and every shadow and held register. Until the first complete frame after reset, each output shows its internal value, `pal_invert` and `phase_reset` stay 0, and this holds whatever the enables are.
- R2: A frame starts when the block is idle and `rtc_in` is 0 in a clock after a clock in which it was 1. That clock is the first clock of slot 0. Each slot lasts SLOT_CLKS clocks, and only the level in the first clock of each slot is used.
- R3: A frame lasts FRAME_SLOTS slots. A falling edge on `rtc_in` while a frame is in progress neither restarts nor shortens it. A new frame can start from the first clock after the last clock of the previous one.
- R4: The subcarrier increment is read most significant bit first, ending at slot 67, so with FSC_W = 22 it sits in slots 46..67. When `ctl_master` is 0, `fsc_inc` equals `fsc_inc_int`.
- R5: When `ctl_master` is 1, `en_colour` is 1 and the held colour bit (slot 75) is 0, `fsc_inc` is `fsc_inc_int`. When that bit is 1, `fsc_inc` is the received increment. When `en_colour` is 0, `fsc_inc` is always the received increment.
- R6: With `ctl_master` and `en_field` both 1, `field_60` is the received field-rate bit from slot 75-3 = 72, where 0 means 50 Hz and 1 means 60 Hz. Otherwise `field_60` follows `field_rate_reg`.
- R7: With `ctl_master` and `en_oddeven` both 1, `odd_even` is the received bit from slot 74. Otherwise it follows `odd_even_int`.
- R8: `phase_reset` is high for exactly one clock, the clock after a frame's last clock. This happens only when the frame's reset bit (slot 69) is 1, `ctl_master` and `en_reset` are 1, and `phres_mode` is 2'b00.
- R9: `pal_invert` is the received sequence bit (slot 68, where 1 means the colour-difference component is inverted) when `ctl_master` and `pal_mode` are both 1. When `pal_mode` is 0 it stays 0.
- R10: Received values reach the outputs together, in the clock after the last clock of slot FRAME_SLOTS-1. Up to and including that last clock, the outputs still show the previous frame.
- R11: The horizontal PLL increment (slots 1..HP_W, most significant bit first) affects no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_in | input | 1 | Serial control stream, idle high |
| ctl_master | input | 1 | Master enable for received values |
| en_reset | input | 1 | Enable for the received phase-reset bit |
| en_field | input | 1 | Enable for the received field-rate bit |
| en_oddeven | input | 1 | Enable for the received odd/even bit |
| en_colour | input | 1 | Enable for the colour-detect gating of the increment |
| phres_mode | input | 2 | Phase-reset mode; only 2'b00 allows the per-line strobe |
| pal_mode | input | 1 | 1 for PAL, 0 for NTSC |
| field_rate_reg | input | 1 | Programmed field-rate bit |
| odd_even_int | input | 1 | Internally generated odd/even flag |
| fsc_inc_int | input | FSC_W | Internally generated subcarrier increment |
| fsc_inc | output | FSC_W | Selected subcarrier increment |
| field_60 | output | 1 | Selected field-rate flag |
| odd_even | output | 1 | Selected odd/even flag |
| phase_reset | output | 1 | One-clock subcarrier phase-reset strobe |
| pal_invert | output | 1 | Inverted-line flag for PAL |

## Verification
The bench builds the block with SLOT_CLKS = 3, FRAME_SLOTS = 128, HP_W = 15 and FSC_W = 22. With three clocks per slot, the phase counter does not wrap at a power of two. Each slot also has two ignored clocks, and the bench drives them with the inverse of the valid bit. That puts falling edges inside a frame and makes any sampling error one clock early or late show up as corrupted data. The full 22-bit increment and the 15-bit horizontal field let the bench place asymmetric patterns next to each other, so a field that is off by one slot changes the observed increment.

// File: rtl/rtc_pkg.sv
// Package: slot positions and flag indices shared by the serial control
// decoder. Positions count slots from the frame-start slot 0.
package rtc_pkg;
    localparam int unsigned HP_FIRST  = 1;   // first slot of horizontal increment
    localparam int unsigned FSC_LAST  = 67;  // last slot of subcarrier increment
    localparam int unsigned NFLAG     = 5;

    // Flag indices inside the flag vector
    localparam int unsigned F_SEQ = 0;
    localparam int unsigned F_RST = 1;
    localparam int unsigned F_FIS = 2;
    localparam int unsigned F_OE  = 3;
    localparam int unsigned F_COL = 4;

    // Slot carrying each flag, indexed as above
    localparam int unsigned FLAG_SLOT [NFLAG] = '{68, 69, 72, 74, 75};

    typedef logic [NFLAG-1:0] rtc_flags_t;
endpackage

// File: rtl/rtc_slot_timer.sv
// Slot timer: finds the frame-start falling edge and steps through
// FRAME_SLOTS slots of SLOT_CLKS clocks each. It raises 'sample' in the
// first clock of every slot after slot 0 and 'frame_end' in the final
// clock of the frame. It assumes SLOT_CLKS >= 2 and ignores edges while busy.
module rtc_slot_timer #(
    parameter int unsigned SLOT_CLKS   = 2,
    parameter int unsigned FRAME_SLOTS = 128,
    localparam int unsigned PH_W       = $clog2(SLOT_CLKS),
    localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_in,
    output logic              busy,
    output logic              sample,
    output logic              frame_end,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(SLOT_CLKS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

    logic              prev_q;
    logic              busy_q;
    logic [PH_W-1:0]   ph_q;
    logic [SLOT_W-1:0] slot_q;
    logic              fall;

    // Purpose: detect a high-to-low transition of the serial line
    assign fall = prev_q & ~rtc_in;

    // Purpose: advance the phase and slot counters through one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            busy_q <= 1'b0;
            ph_q   <= '0;
            slot_q <= '0;
        end else begin
            prev_q <= rtc_in;
            if (!busy_q) begin
                if (fall) begin
                    busy_q <= 1'b1;
                    ph_q   <= PH_W'(1);
                    slot_q <= '0;
                end
            end else if (ph_q == PH_LAST) begin
                ph_q <= '0;
                if (slot_q == SLOT_LAST) begin
                    busy_q <= 1'b0;
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    assign busy      = busy_q;
    assign sample    = busy_q && (ph_q == '0);
    assign frame_end = busy_q && (ph_q == PH_LAST) && (slot_q == SLOT_LAST);
    assign slot_idx  = slot_q;
endmodule

// File: rtl/rtc_field_capture.sv
// Field capture: shifts the two increments into shadow registers and
// latches each flag in its slot. At frame end it copies the shadows into
// held registers in one clock. It assumes the slot layout in rtc_pkg and
// that the horizontal field ends before the subcarrier field begins.
module rtc_field_capture
    import rtc_pkg::*;
#(
    parameter int unsigned HP_W   = 15,
    parameter int unsigned FSC_W  = 22,
    parameter int unsigned SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_in,
    input  logic              sample,
    input  logic              frame_end,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic [HP_W-1:0]   hp_shadow,
    output logic [FSC_W-1:0]  fsc_held,
    output rtc_flags_t        flags_held,
    output logic              have_frame,
    output logic              commit
);
    localparam int unsigned HP_LAST   = HP_FIRST + HP_W - 1;
    localparam int unsigned FSC_FIRST = FSC_LAST - FSC_W + 1;

    logic [HP_W-1:0]  hp_sh;
    logic [FSC_W-1:0] fsc_sh;
    rtc_flags_t       flag_sh;
    logic             in_hp, in_fsc;
    int unsigned      slot_n;

    // Purpose: decode which increment window the current slot is in
    always_comb begin
        slot_n = int'(slot_idx);
        in_hp  = (slot_n >= HP_FIRST)  && (slot_n <= HP_LAST);
        in_fsc = (slot_n >= FSC_FIRST) && (slot_n <= FSC_LAST);
    end

    // Purpose: shift both increments in, most significant bit first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_sh  <= '0;
            fsc_sh <= '0;
        end else if (sample) begin
            if (in_hp)  hp_sh  <= {hp_sh[HP_W-2:0], rtc_in};
            if (in_fsc) fsc_sh <= {fsc_sh[FSC_W-2:0], rtc_in};
        end
    end

    // One shadow flop per flag, each loaded in its own slot
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic bit_q;
        // Purpose: latch this flag when its slot is sampled
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (sample && (slot_n == FLAG_SLOT[i]))
                bit_q <= rtc_in;
        end
        assign flag_sh[i] = bit_q;
    end

    // Purpose: move all shadows to the held registers at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsc_held   <= '0;
            flags_held <= '0;
            have_frame <= 1'b0;
            commit     <= 1'b0;
        end else begin
            commit <= frame_end;
            if (frame_end) begin
                fsc_held   <= fsc_sh;
                flags_held <= flag_sh;
                have_frame <= 1'b1;
            end
        end
    end

    assign hp_shadow = hp_sh;
endmodule

// File: rtl/rtc_output_select.sv
// Output select: for each output, picks the held received value or the
// internal value according to the master and per-field enables, and forms
// the one-clock phase-reset strobe from the commit pulse. Purely combinational.
module rtc_output_select
    import rtc_pkg::*;
#(
    parameter int unsigned FSC_W = 22
) (
    input  logic             ctl_master,
    input  logic             en_reset,
    input  logic             en_field,
    input  logic             en_oddeven,
    input  logic             en_colour,
    input  logic [1:0]       phres_mode,
    input  logic             pal_mode,
    input  logic             field_rate_reg,
    input  logic             odd_even_int,
    input  logic [FSC_W-1:0] fsc_inc_int,
    input  logic [FSC_W-1:0] fsc_held,
    input  rtc_flags_t       flags_held,
    input  logic             have_frame,
    input  logic             commit,
    output logic [FSC_W-1:0] fsc_inc,
    output logic             field_60,
    output logic             odd_even,
    output logic             phase_reset,
    output logic             pal_invert
);
    logic live;
    logic use_rx_fsc;

    // Purpose: choose each output from received or internal values
    always_comb begin
        live        = ctl_master && have_frame;
        use_rx_fsc  = live && (!en_colour || flags_held[F_COL]);
        fsc_inc     = use_rx_fsc ? fsc_held : fsc_inc_int;
        field_60    = (live && en_field)   ? flags_held[F_FIS] : field_rate_reg;
        odd_even    = (live && en_oddeven) ? flags_held[F_OE]  : odd_even_int;
        pal_invert  = live && pal_mode && flags_held[F_SEQ];
        phase_reset = commit && ctl_master && en_reset &&
                      (phres_mode == 2'b00) && flags_held[F_RST];
    end
endmodule

// File: rtl/rtc_line_decoder.sv
// Top of the serial real-time control decoder. It joins the slot timer,
// the field capture and the output selector. It assumes the stream idles
// high and that the configuration inputs are quasi-static.
module rtc_line_decoder
    import rtc_pkg::*;
#(
    parameter int unsigned SLOT_CLKS   = 2,
    parameter int unsigned FRAME_SLOTS = 128,
    parameter int unsigned HP_W        = 15,
    parameter int unsigned FSC_W       = 22,
    localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_in,
    input  logic             ctl_master,
    input  logic             en_reset,
    input  logic             en_field,
    input  logic             en_oddeven,
    input  logic             en_colour,
    input  logic [1:0]       phres_mode,
    input  logic             pal_mode,
    input  logic             field_rate_reg,
    input  logic             odd_even_int,
    input  logic [FSC_W-1:0] fsc_inc_int,
    output logic [FSC_W-1:0] fsc_inc,
    output logic             field_60,
    output logic             odd_even,
    output logic             phase_reset,
    output logic             pal_invert
);
    logic              busy, sample, frame_end, have_frame, commit;
    logic [SLOT_W-1:0] slot_idx;
    logic [HP_W-1:0]   hp_shadow;
    logic [FSC_W-1:0]  fsc_held;
    rtc_flags_t        flags_held;

    rtc_slot_timer #(
        .SLOT_CLKS  (SLOT_CLKS),
        .FRAME_SLOTS(FRAME_SLOTS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rtc_in   (rtc_in),
        .busy     (busy),
        .sample   (sample),
        .frame_end(frame_end),
        .slot_idx (slot_idx)
    );

    rtc_field_capture #(
        .HP_W  (HP_W),
        .FSC_W (FSC_W),
        .SLOT_W(SLOT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_in    (rtc_in),
        .sample    (sample),
        .frame_end (frame_end),
        .slot_idx  (slot_idx),
        .hp_shadow (hp_shadow),
        .fsc_held  (fsc_held),
        .flags_held(flags_held),
        .have_frame(have_frame),
        .commit    (commit)
    );

    rtc_output_select #(
        .FSC_W(FSC_W)
    ) u_select (
        .ctl_master    (ctl_master),
        .en_reset      (en_reset),
        .en_field      (en_field),
        .en_oddeven    (en_oddeven),
        .en_colour     (en_colour),
        .phres_mode    (phres_mode),
        .pal_mode      (pal_mode),
        .field_rate_reg(field_rate_reg),
        .odd_even_int  (odd_even_int),
        .fsc_inc_int   (fsc_inc_int),
        .fsc_held      (fsc_held),
        .flags_held    (flags_held),
        .have_frame    (have_frame),
        .commit        (commit),
        .fsc_inc       (fsc_inc),
        .field_60      (field_60),
        .odd_even      (odd_even),
        .phase_reset   (phase_reset),
        .pal_invert    (pal_invert)
    );
endmodule

// File: rtl/rtc_line_decoder_chk.sv
// Checker for rtc_line_decoder: temporal properties over the frame timer,
// the held registers and the outputs. Attached by the bind at the bottom.
module rtc_line_decoder_chk
    import rtc_pkg::*;
#(
    parameter int unsigned SLOT_CLKS   = 2,
    parameter int unsigned FRAME_SLOTS = 128,
    parameter int unsigned HP_W        = 15,
    parameter int unsigned FSC_W       = 22,
    localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sample,
    input logic              frame_end,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [HP_W-1:0]   hp_shadow,
    input logic [FSC_W-1:0]  fsc_held,
    input logic              ctl_master,
    input logic [FSC_W-1:0]  fsc_inc_int,
    input logic [FSC_W-1:0]  fsc_inc,
    input logic              phase_reset,
    input logic              pal_invert
);
    logic in_hp_win;
    assign in_hp_win = sample && (int'(slot_idx) >= HP_FIRST) &&
                       (int'(slot_idx) <= HP_FIRST + HP_W - 1);

    // R2: two valid samples are never in adjacent clocks
    a_r2_sample_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    // R3: a frame in progress keeps running until its last clock
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end) |=> busy);

    // R3: the timer goes idle after the last clock of a frame
    a_r3_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !busy);

    // R4: with the master enable off, the internal increment passes through
    a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_master |-> (fsc_inc == fsc_inc_int) && !pal_invert && !phase_reset);

    // R8: the phase-reset strobe lasts one clock
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        phase_reset |=> !phase_reset);

    // R8: the strobe only follows a frame end
    a_r8_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        phase_reset |-> $past(frame_end));

    // R10: the held increment changes only at frame end
    a_r10_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(fsc_held));

    // R11: the horizontal shadow moves only in its own slots
    a_r11_hp_window: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hp_win |=> $stable(hp_shadow));
endmodule

bind rtc_line_decoder rtc_line_decoder_chk #(
    .SLOT_CLKS  (SLOT_CLKS),
    .FRAME_SLOTS(FRAME_SLOTS),
    .HP_W       (HP_W),
    .FSC_W      (FSC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .sample     (sample),
    .frame_end  (frame_end),
    .slot_idx   (slot_idx),
    .hp_shadow  (hp_shadow),
    .fsc_held   (fsc_held),
    .ctl_master (ctl_master),
    .fsc_inc_int(fsc_inc_int),
    .fsc_inc    (fsc_inc),
    .phase_reset(phase_reset),
    .pal_invert (pal_invert)
);

// File: tb/rtc_line_decoder_test.sv
`timescale 1ns/1ps
// Directed bench for rtc_line_decoder: one task per scenario.
module rtc_line_decoder_test;
    localparam int SC = 3;
    localparam int FS = 128;
    localparam int HW = 15;
    localparam int FW = 22;
    localparam logic [FW-1:0] INT_FSC = 22'h155555;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rtc_in = 1'b1;
    logic          ctl_master = 1'b1, en_reset = 1'b1, en_field = 1'b1;
    logic          en_oddeven = 1'b1, en_colour = 1'b0, pal_mode = 1'b1;
    logic [1:0]    phres_mode = 2'b00;
    logic          field_rate_reg = 1'b0, odd_even_int = 1'b0;
    logic [FW-1:0] fsc_inc_int = INT_FSC;
    logic [FW-1:0] fsc_inc;
    logic          field_60, odd_even, phase_reset, pal_invert;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rtc_line_decoder #(.SLOT_CLKS(SC), .FRAME_SLOTS(FS), .HP_W(HW), .FSC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .rtc_in(rtc_in), .ctl_master(ctl_master),
        .en_reset(en_reset), .en_field(en_field), .en_oddeven(en_oddeven),
        .en_colour(en_colour), .phres_mode(phres_mode), .pal_mode(pal_mode),
        .field_rate_reg(field_rate_reg), .odd_even_int(odd_even_int),
        .fsc_inc_int(fsc_inc_int), .fsc_inc(fsc_inc), .field_60(field_60),
        .odd_even(odd_even), .phase_reset(phase_reset), .pal_invert(pal_invert));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Sends one frame. The first clock of each slot carries the bit; with
    // noisy set, the other clocks carry its inverse. Checks that fsc_inc is
    // unchanged up to the last frame clock, and returns one negedge after
    // the commit edge.
    task automatic send_frame(input logic [FW-1:0] fsc, input logic [HW-1:0] hp,
                              input logic seq, input logic rs, input logic fis,
                              input logic oe, input logic col, input logic noisy);
        logic [FS-1:0] b;
        logic [FW-1:0] old;
        b = '1;
        b[0] = 1'b0;
        for (int i = 0; i < HW; i++) b[1 + i]  = hp[HW - 1 - i];
        for (int i = 0; i < FW; i++) b[46 + i] = fsc[FW - 1 - i];
        b[68] = seq; b[69] = rs; b[72] = fis; b[74] = oe; b[75] = col;
        @(negedge clk);
        old = fsc_inc;
        for (int k = 0; k < FS; k++) begin
            for (int c = 0; c < SC; c++) begin
                if (!(k == 0 && c == 0)) @(negedge clk);
                rtc_in = (c == 0) ? b[k] : (noisy ? ~b[k] : b[k]);
            end
        end
        check("R10 unchanged before last edge", 32'(fsc_inc), 32'(old));
        @(negedge clk);
        rtc_in = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 fsc internal", 32'(fsc_inc), 32'(INT_FSC));
        check("R1 field internal", 32'(field_60), 32'(field_rate_reg));
        check("R1 oddeven internal", 32'(odd_even), 32'(odd_even_int));
        check("R1 pal clear", 32'(pal_invert), 0);
        check("R1 phase clear", 32'(phase_reset), 0);
    endtask

    task automatic t_basic;
        send_frame(22'h3C0F1A, 15'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 received fsc", 32'(fsc_inc), 32'h3C0F1A);
        check("R6 received field", 32'(field_60), 1);
        check("R7 received oddeven", 32'(odd_even), 1);
    endtask

    task automatic t_noise;
        send_frame(22'h0F00F3, 15'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 noisy invalid clocks ignored", 32'(fsc_inc), 32'h0F00F3);
        check("R2 noisy field", 32'(field_60), 0);
        check("R2 noisy oddeven", 32'(odd_even), 0);
        send_frame(22'h2DEAD1, 15'h0F0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R3 back-to-back frame", 32'(fsc_inc), 32'h2DEAD1);
        check("R3 back-to-back field", 32'(field_60), 1);
    endtask

    task automatic t_colour;
        en_colour = 1'b1;
        send_frame(22'h012345, 15'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 colour 0 -> internal", 32'(fsc_inc), 32'(INT_FSC));
        send_frame(22'h2A0F55, 15'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R5 colour 1 -> received", 32'(fsc_inc), 32'h2A0F55);
        en_colour = 1'b0;
        send_frame(22'h1F00E1, 15'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 colour enable off -> received", 32'(fsc_inc), 32'h1F00E1);
    endtask

    task automatic t_enables;
        en_field = 1'b0; en_oddeven = 1'b0;
        field_rate_reg = 1'b1; odd_even_int = 1'b0;
        send_frame(22'h0A5A5A, 15'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 field enable off", 32'(field_60), 1);
        check("R7 oddeven enable off", 32'(odd_even), 0);
        field_rate_reg = 1'b0; odd_even_int = 1'b1;
        @(negedge clk);
        check("R6 follows programmed bit", 32'(field_60), 0);
        check("R7 follows internal flag", 32'(odd_even), 1);
        en_field = 1'b1; en_oddeven = 1'b1;
        @(negedge clk);
        check("R6 held bit restored", 32'(field_60), 0);
        check("R7 held bit restored", 32'(odd_even), 1);
    endtask

    task automatic t_phase;
        send_frame(22'h111111, 15'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 strobe high", 32'(phase_reset), 1);
        @(negedge clk);
        check("R8 strobe one clock", 32'(phase_reset), 0);
        phres_mode = 2'b01;
        send_frame(22'h222222, 15'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 mode 01 blocks strobe", 32'(phase_reset), 0);
        phres_mode = 2'b00;
        send_frame(22'h333333, 15'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 reset bit 0 no strobe", 32'(phase_reset), 0);
        en_reset = 1'b0;
        send_frame(22'h044444, 15'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 enable off no strobe", 32'(phase_reset), 0);
        en_reset = 1'b1;
    endtask

    task automatic t_pal;
        send_frame(22'h055555, 15'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 inverted line", 32'(pal_invert), 1);
        send_frame(22'h066666, 15'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 normal line", 32'(pal_invert), 0);
        pal_mode = 1'b0;
        send_frame(22'h077777, 15'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 NTSC no effect", 32'(pal_invert), 0);
        pal_mode = 1'b1;
        @(negedge clk);
        check("R9 PAL flag from held bit", 32'(pal_invert), 1);
    endtask

    task automatic t_hpll;
        send_frame(22'h2B3C4D, 15'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R11 hp all ones fsc", 32'(fsc_inc), 32'h2B3C4D);
        send_frame(22'h0C3C4D, 15'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R11 hp all zeros fsc", 32'(fsc_inc), 32'h0C3C4D);
        check("R11 field unaffected", 32'(field_60), 0);
        check("R11 oddeven unaffected", 32'(odd_even), 1);
    endtask

    task automatic t_master;
        ctl_master = 1'b0;
        send_frame(22'h3FFFF0, 15'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 master off fsc", 32'(fsc_inc), 32'(INT_FSC));
        check("R4 master off strobe", 32'(phase_reset), 0);
        check("R6 master off field", 32'(field_60), 32'(field_rate_reg));
        check("R9 master off pal", 32'(pal_invert), 0);
        ctl_master = 1'b1;
        @(negedge clk);
        check("R4 master on uses held", 32'(fsc_inc), 32'h3FFFF0);
        check("R7 master on held oddeven", 32'(odd_even), 0);
    endtask

    task automatic t_reset_again;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset drops held values", 32'(fsc_inc), 32'(INT_FSC));
        check("R1 reset drops held oddeven", 32'(odd_even), 32'(odd_even_int));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_noise();
        t_colour();
        t_enables();
        t_phase();
        t_pal();
        t_hpll();
        t_master();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule